// File: doc/BRIEF.md
# Packed Integer Dot-Product Accumulator

This unit multiplies short integer vectors packed into two 32-bit source words, sums the element products, and adds that sum to a 32-bit accumulator operand. It accepts one operation per clock and returns the new accumulator value one clock later. It is intended as an execution lane for low-precision integer inference kernels. Each instruction reduces several narrow products into one wide partial sum.

Two packings are supported. In quad mode, each source carries four bytes and the unit sums four byte-by-byte products. In pair mode, source A carries two 16-bit halfwords and source B supplies two bytes, taken from its lower or upper half. Each source has its own signedness control, so any mix of signed and unsigned operands can be expressed. The final addition wraps modulo 2^32 and never saturates.

Top module: `pdot_acc_unit`

## Requirements
- R1: With `op_mode`=0 (quad), the result is the sum of `src_a` byte i times `src_b` byte i for i = 0..3, plus `acc_in`. Byte i occupies bits [8i+7:8i].
- R2: With `op_mode`=1 (pair), the result is the sum of `src_a` halfword j (bits [16j+15:16j]) times a `src_b` byte, for j = 0..1, plus `acc_in`. When `b_hi_sel`=0 the byte is bits [8j+7:8j]; when `b_hi_sel`=1 it is bits [8j+23:8j+16].
- R3: `a_sgn`=1 treats every element of `src_a` as two's complement; `a_sgn`=0 treats it as unsigned.
- R4: `b_sgn`=1 treats every element of `src_b` as two's complement; `b_sgn`=0 treats it as unsigned.
- R5: The accumulation wraps modulo 2^32 with no saturation. An all-zero `src_a` returns `acc_in` unchanged.
- R6: A request with `in_vld`=1 produces `out_vld`=1 and its result exactly one clock later. Requests may arrive on consecutive cycles.
- R7: After a cycle with `in_vld`=0, `out_vld` is 0 and `out_res` keeps its previous value.
- R8: While reset is asserted, `out_vld` and `out_res` are 0.
- R9: In quad mode, `b_hi_sel` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| in_vld | input | 1 | Request valid |
| op_mode | input | 1 | 0 = four bytes by four bytes, 1 = two halfwords by two bytes |
| a_sgn | input | 1 | Signedness of `src_a` elements |
| b_sgn | input | 1 | Signedness of `src_b` elements |
| b_hi_sel | input | 1 | Pair mode: take `src_b` bytes from the upper half |
| src_a | input | 32 | Packed vector A |
| src_b | input | 32 | Packed vector B |
| acc_in | input | 32 | Accumulator operand |
| out_vld | output | 1 | Result valid |
| out_res | output | 32 | Accumulated dot product |

## Verification
The assertions assume that the control and data inputs are at known levels whenever `in_vld` is high, and that `in_vld` itself is never unknown after reset. The lane-sign check also assumes that an unsigned-by-unsigned product can never be negative. The bench drives every input from a defined value on the falling edge, and holds the previous operands during idle gaps. The only deliberate idle stimulus is `in_vld` low, and that is exactly what the hold checks rely on.

// File: rtl/pdot_pkg.sv
package pdot_pkg;
  localparam int unsigned PD_WORD = 32;
  localparam int unsigned PD_BYTE = 8;
  localparam int unsigned PD_HALF = 16;

  typedef enum logic {
    PD_QUAD = 1'b0,
    PD_PAIR = 1'b1
  } pd_mode_e;
endpackage

// File: rtl/pdot_rst_sync.sv
module pdot_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pdot_lane_mul.sv
module pdot_lane_mul #(
  parameter int unsigned AW = 8,
  parameter int unsigned BW = 8,
  localparam int unsigned PW = AW + BW + 2
) (
  input  logic [AW-1:0]        a_el,
  input  logic [BW-1:0]        b_el,
  input  logic                 a_sgn,
  input  logic                 b_sgn,
  output logic signed [PW-1:0] prod
);
  logic signed [AW:0]   a_x;
  logic signed [BW:0]   b_x;
  logic signed [PW-1:0] a_w;
  logic signed [PW-1:0] b_w;

  always_comb begin
    // one extra bit: the element's sign when signed, zero when unsigned
    a_x  = {a_sgn & a_el[AW-1], a_el};
    b_x  = {b_sgn & b_el[BW-1], b_el};
    a_w  = PW'(a_x);
    b_w  = PW'(b_x);
    prod = a_w * b_w;
  end
endmodule

// File: rtl/pdot_acc_unit.sv
module pdot_acc_unit
  import pdot_pkg::*;
#(
  parameter int unsigned WORD = PD_WORD
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic            op_mode,
  input  logic            a_sgn,
  input  logic            b_sgn,
  input  logic            b_hi_sel,
  input  logic [WORD-1:0] src_a,
  input  logic [WORD-1:0] src_b,
  input  logic [WORD-1:0] acc_in,
  output logic            out_vld,
  output logic [WORD-1:0] out_res
);
  localparam int unsigned NQ  = WORD / PD_BYTE;
  localparam int unsigned NP  = WORD / PD_HALF;
  localparam int unsigned QPW = 2 * PD_BYTE + 2;
  localparam int unsigned PPW = PD_HALF + PD_BYTE + 2;

  logic rst_s_n;

  pdot_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  logic signed [QPW-1:0] q_prod [NQ];
  logic signed [PPW-1:0] p_prod [NP];

  for (genvar g = 0; g < NQ; g++) begin : g_quad
    pdot_lane_mul #(.AW(PD_BYTE), .BW(PD_BYTE)) u_mul (
      .a_el  (src_a[PD_BYTE*g +: PD_BYTE]),
      .b_el  (src_b[PD_BYTE*g +: PD_BYTE]),
      .a_sgn (a_sgn),
      .b_sgn (b_sgn),
      .prod  (q_prod[g])
    );

    AST_LANE_NONNEG: assert property (@(posedge clk) disable iff (!rst_s_n)
      (in_vld && !a_sgn && !b_sgn) |-> !q_prod[g][QPW-1]); // R3
  end

  for (genvar g = 0; g < NP; g++) begin : g_pair
    logic [PD_BYTE-1:0] b_pick;
    always_comb b_pick = b_hi_sel ? src_b[WORD/2 + PD_BYTE*g +: PD_BYTE]
                                  : src_b[PD_BYTE*g +: PD_BYTE];

    pdot_lane_mul #(.AW(PD_HALF), .BW(PD_BYTE)) u_mul (
      .a_el  (src_a[PD_HALF*g +: PD_HALF]),
      .b_el  (b_pick),
      .a_sgn (a_sgn),
      .b_sgn (b_sgn),
      .prod  (p_prod[g])
    );
  end

  logic [WORD-1:0] dot_q, dot_p, res_d;
  logic            vld_d;

  always_comb begin
    dot_q = '0;
    for (int i = 0; i < NQ; i++) dot_q = dot_q + WORD'(q_prod[i]);
    dot_p = '0;
    for (int i = 0; i < NP; i++) dot_p = dot_p + WORD'(p_prod[i]);
    res_d = acc_in + ((pd_mode_e'(op_mode) == PD_PAIR) ? dot_p : dot_q);
    vld_d = in_vld;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)    out_vld <= 1'b0;
    else             out_vld <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)    out_res <= '0;
    else if (in_vld) out_res <= res_d;
  end

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_s_n)
    in_vld |=> out_vld); // R6
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_s_n)
    !in_vld |=> !out_vld); // R7
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    !in_vld |=> $stable(out_res)); // R7
  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (in_vld && src_a == '0) |=> out_res == $past(acc_in)); // R5
endmodule

// File: tb/sim_pdot_acc_unit.sv
`timescale 1ns/1ps
module sim_pdot_acc_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld, op_mode, a_sgn, b_sgn, b_hi_sel;
  logic [31:0] src_a, src_b, acc_in;
  logic        out_vld;
  logic [31:0] out_res;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] last_res;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  pdot_acc_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_mode(op_mode),
    .a_sgn(a_sgn), .b_sgn(b_sgn), .b_hi_sel(b_hi_sel),
    .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
    .out_vld(out_vld), .out_res(out_res)
  );

  function automatic longint elem(input logic [15:0] v, input int w, input logic sg);
    longint x = longint'(v & ((16'h1 << w) - 1));
    if (sg && v[w-1]) x = x - (longint'(1) << w);
    return x;
  endfunction

  function automatic logic [31:0] model(input logic md, input logic sa, input logic sb,
                                        input logic hs, input logic [31:0] a,
                                        input logic [31:0] b, input logic [31:0] acc);
    longint s = longint'(acc);
    if (!md) begin
      for (int i = 0; i < 4; i++)
        s += elem({8'h0, a[8*i +: 8]}, 8, sa) * elem({8'h0, b[8*i +: 8]}, 8, sb);
    end else begin
      for (int j = 0; j < 2; j++)
        s += elem(a[16*j +: 16], 16, sa) * elem({8'h0, b[8*j + 16*hs +: 8]}, 8, sb);
    end
    return s[31:0];
  endfunction

  function automatic void check(input bit ok, input string tag,
                                input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  task automatic drive(input logic md, input logic sa, input logic sb, input logic hs,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] acc, input string tag);
    @(negedge clk);
    in_vld = 1'b1; op_mode = md; a_sgn = sa; b_sgn = sb; b_hi_sel = hs;
    src_a = a; src_b = b; acc_in = acc;
    exp_q.push_back(model(md, sa, sb, hs, a, b, acc));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_vld = 1'b0;
    end
  endtask

  // monitor: samples on the falling edge, half a period after the register edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_vld) begin
        if (exp_q.size() == 0) check(1'b0, "R6 unexpected out_vld", out_res, 32'h0);
        else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_res === e, t, out_res, e);
        end
      end else if (exp_q.size() == 0) begin
        check(out_res === last_res, "R7 hold when idle", out_res, last_res);
      end
      last_res = out_res;
    end
  end

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; op_mode = 1'b0; a_sgn = 1'b0; b_sgn = 1'b0;
    b_hi_sel = 1'b0; src_a = '0; src_b = '0; acc_in = '0; last_res = '0;
    repeat (3) @(negedge clk);
    check(out_vld === 1'b0, "R8 reset out_vld", {31'h0, out_vld}, 32'h0);
    check(out_res === 32'h0, "R8 reset out_res", out_res, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R3 / R4 quad extremes
    drive(0, 1, 1, 0, 32'h80808080, 32'h80808080, 32'h0, "R1 R3 R4 quad all -128");
    drive(0, 0, 0, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h5, "R1 quad all 255 unsigned");
    drive(0, 1, 0, 0, 32'h80808080, 32'hFFFFFFFF, 32'h0, "R3 signed -128 x unsigned 255");
    drive(0, 0, 1, 0, 32'hFFFFFFFF, 32'h80808080, 32'h0, "R4 unsigned 255 x signed -128");
    drive(0, 1, 1, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, "R3 R4 quad all -1 signed");
    drive(0, 0, 0, 0, 32'h04030201, 32'h01000000, 32'h0, "R1 element order");
    // R9 b_hi_sel ignored in quad
    drive(0, 1, 0, 1, 32'h7F80017E, 32'h12345678, 32'h100, "R9 quad hi_sel=1");
    drive(0, 1, 0, 0, 32'h7F80017E, 32'h12345678, 32'h100, "R9 quad hi_sel=0");
    // R2 pair mode
    drive(1, 1, 1, 0, 32'h80008000, 32'h00008080, 32'h0, "R2 pair -32768 x -128 low");
    drive(1, 0, 0, 1, 32'hFFFFFFFF, 32'hFFFF0000, 32'h0, "R2 pair unsigned max high");
    drive(1, 1, 0, 1, 32'h00020003, 32'h0705AAAA, 32'h0, "R2 pair high bytes order");
    drive(1, 0, 1, 0, 32'hFFFF0001, 32'h0000FF80, 32'h0, "R2 R4 pair mixed sign");
    // R5 wrap and zero pass-through
    drive(0, 0, 0, 0, 32'h00000001, 32'h00000001, 32'h7FFFFFFF, "R5 wrap positive");
    drive(0, 1, 1, 0, 32'h000000FF, 32'h00000001, 32'h00000000, "R5 wrap below zero");
    drive(1, 1, 1, 0, 32'h00000000, 32'hFFFFFFFF, 32'hDEADBEEF, "R5 zero A passes acc");
    idle(3);
    // R6 back-to-back random, R7 gaps
    for (int n = 0; n < 300; n++) begin
      drive($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
            $urandom_range(0, 1), $urandom, $urandom, $urandom, "R6 random vector");
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(4);
    check(exp_q.size() == 0, "R6 all results returned", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule